// File: doc/BRIEF.md
# Serial Trigger Status Capture Register

This block gathers trigger and sweep activity between readouts and hands a 16-bit status word to a controller over a two-wire serial path. Single-cycle event pulses for the A and B triggers and for main sweep gates set a group of primary latches. A small counter tallies the gates, and a level tracks whether an armed single-sequence acquisition is still running.

A snapshot copies the primary latches into a storage shift register and clears them, so activity keeps building up for the next read. A snapshot is taken when the controller pulses a shift-register-update request, and again when a full 16-bit readout finishes. The controller pulses an active-low strobe once per bit. The block presents the next bit on its data output only after the strobe returns high, so the controller samples each bit before it issues the next strobe.

Top module: `trig_status_capture`

## Requirements
- R1: After reset the data output is 0, and a snapshot taken with no events since reset yields the word 0x0000.
- R2: The word is sent MSB first. Bit 15 is on the data output in the cycle after a snapshot, before any strobe. Each strobe pulse (strobe low, then high again) advances the output to the next lower bit.
- R3: While the strobe is held low and no update request arrives, the data output does not change.
- R4: Bit 11 of the word is 1 when an A trigger pulse occurred since the previous snapshot.
- R5: Bit 10 of the word is 1 when a B trigger pulse occurred since the previous snapshot.
- R6: Bits 15:12 hold the number of main sweep gate pulses since the previous snapshot. The count saturates at 15 and does not wrap.
- R7: Bit 0 is 1 while a single sequence is running. It is set by a single-arm pulse and cleared by a single-done pulse. A snapshot does not clear it.
- R8: The rising strobe edge that ends bit 0 of a frame takes a new snapshot, which clears the trigger flags and the gate count. The next frame then starts at its MSB.
- R9: An update request in the middle of a frame takes a new snapshot and restarts the frame at the MSB of the new word.
- R10: An event pulse in the same cycle as a snapshot is not lost. It appears in the word of the following snapshot.
- R11: Bits 9 down to 1 of the word always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| aTrigPulse | input | 1 | One-cycle pulse when the A trigger fires |
| bTrigPulse | input | 1 | One-cycle pulse when the B trigger fires |
| gatePulse | input | 1 | One-cycle pulse at the start of each main sweep gate |
| singleArm | input | 1 | Pulse that starts a single-sequence acquisition |
| singleDone | input | 1 | Pulse that marks the single sequence as complete |
| shiftUpdate | input | 1 | Snapshot request from an input shift register update |
| strobeN | input | 1 | Active-low readout strobe from the controller |
| dataOut | output | 1 | Serial status bit |

## Verification
The assertions are checked on every cycle and cover the local invariants:
- the shift register and bit index hold while the strobe stays low;
- the gate counter sticks at its maximum;
- a snapshot clears the flags, except for an event that arrives in the same cycle as the snapshot;
- a single-done pulse clears the busy level;
- the last rising strobe edge returns the frame index to zero.

Only the bench scenarios can show the end-to-end properties. These are the MSB-first bit order at the pins, the split between the word being read and the events gathered during that read, the restart after a mid-frame update, and the reserved bits reading zero across many different words.

// File: rtl/trig_status_pkg.sv
package trig_status_pkg;
  typedef struct packed {
    logic snap;   // copy primary latches to storage, clear primary
    logic shift;  // advance serial output by one bit
  } ctlStrobes_t;
endpackage

// File: rtl/trig_status_ctrl.sv
module trig_status_ctrl
  import trig_status_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        strobeN,
  input  logic        shiftUpdate,
  output ctlStrobes_t ctl
);
  localparam int IDX_W = $clog2(WORD_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

  logic             strobePrev;
  logic [IDX_W-1:0] bitIdx;
  logic             strobeRise;
  logic             lastBit;

  assign strobeRise = strobeN & ~strobePrev;
  assign lastBit    = (bitIdx == LAST_IDX);

  always_comb begin
    ctl.snap  = shiftUpdate | (strobeRise & lastBit);
    ctl.shift = strobeRise & ~lastBit & ~shiftUpdate;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strobePrev <= 1'b1;
      bitIdx     <= '0;
    end else begin
      strobePrev <= strobeN;
      if (ctl.snap)       bitIdx <= '0;
      else if (ctl.shift) bitIdx <= bitIdx + 1'b1;
    end
  end

  // R3: a held-low strobe never moves the frame position
  p_idx_hold_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobeN && !shiftUpdate) |=> $stable(bitIdx));

  // R8: the strobe ending the final bit starts a fresh frame
  p_frame_wrap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobeN && !strobePrev && bitIdx == LAST_IDX) |=> (bitIdx == '0));

  // R9: an update request always restarts the frame
  p_update_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    shiftUpdate |=> (bitIdx == '0));
endmodule

// File: rtl/trig_status_datapath.sv
module trig_status_datapath
  import trig_status_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int CNT_W     = 4,
  parameter int ATRIG_BIT = 11,
  parameter int BTRIG_BIT = 10,
  parameter int BUSY_BIT  = 0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        aTrigPulse,
  input  logic        bTrigPulse,
  input  logic        gatePulse,
  input  logic        singleArm,
  input  logic        singleDone,
  input  ctlStrobes_t ctl,
  output logic        serialBit
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  // primary latches
  logic             aTrigSeen;
  logic             bTrigSeen;
  logic [CNT_W-1:0] gateCnt;
  logic             singleBusy;
  // storage latches, read out serially
  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] snapWord;

  always_comb begin
    snapWord                     = '0;
    snapWord[WORD_W-1 -: CNT_W]  = gateCnt;
    snapWord[ATRIG_BIT]          = aTrigSeen;
    snapWord[BTRIG_BIT]          = bTrigSeen;
    snapWord[BUSY_BIT]           = singleBusy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aTrigSeen <= 1'b0;
      bTrigSeen <= 1'b0;
      gateCnt   <= '0;
    end else if (ctl.snap) begin
      // clear, but keep an event arriving in the snapshot cycle
      aTrigSeen <= aTrigPulse;
      bTrigSeen <= bTrigPulse;
      gateCnt   <= gatePulse ? CNT_ONE : '0;
    end else begin
      if (aTrigPulse) aTrigSeen <= 1'b1;
      if (bTrigPulse) bTrigSeen <= 1'b1;
      if (gatePulse && gateCnt != CNT_MAX) gateCnt <= gateCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           singleBusy <= 1'b0;
    else if (singleArm)  singleBusy <= 1'b1;
    else if (singleDone) singleBusy <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          shiftReg <= '0;
    else if (ctl.snap)  shiftReg <= snapWord;
    else if (ctl.shift) shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
  end

  assign serialBit = shiftReg[WORD_W-1];

  // R3: storage is frozen unless a snapshot or shift is commanded
  p_store_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.snap && !ctl.shift) |=> $stable(shiftReg));

  // R6: the gate count sticks at its maximum
  p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (gateCnt == CNT_MAX && !ctl.snap) |=> (gateCnt == CNT_MAX));

  // R8: a snapshot with no new A trigger clears the flag
  p_snap_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.snap && !aTrigPulse) |=> !aTrigSeen);

  // R10: a trigger coinciding with a snapshot survives it
  p_same_cycle_keep_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.snap && aTrigPulse) |=> aTrigSeen);

  // R7: done without arm ends the single sequence
  p_single_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    (singleDone && !singleArm) |=> !singleBusy);
endmodule

// File: rtl/trig_status_capture.sv
module trig_status_capture
  import trig_status_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int CNT_W     = 4,
  parameter int ATRIG_BIT = 11,
  parameter int BTRIG_BIT = 10,
  parameter int BUSY_BIT  = 0
) (
  input  logic clk,
  input  logic rstN,
  input  logic aTrigPulse,
  input  logic bTrigPulse,
  input  logic gatePulse,
  input  logic singleArm,
  input  logic singleDone,
  input  logic shiftUpdate,
  input  logic strobeN,
  output logic dataOut
);
  ctlStrobes_t ctl;

  trig_status_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .strobeN(strobeN),
    .shiftUpdate(shiftUpdate), .ctl(ctl)
  );

  trig_status_datapath #(
    .WORD_W(WORD_W), .CNT_W(CNT_W), .ATRIG_BIT(ATRIG_BIT),
    .BTRIG_BIT(BTRIG_BIT), .BUSY_BIT(BUSY_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .aTrigPulse(aTrigPulse), .bTrigPulse(bTrigPulse),
    .gatePulse(gatePulse), .singleArm(singleArm), .singleDone(singleDone),
    .ctl(ctl), .serialBit(dataOut)
  );
endmodule

// File: tb/trig_status_capture_tb.sv
module trig_status_capture_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic aTrigPulse = 0, bTrigPulse = 0, gatePulse = 0;
  logic singleArm = 0, singleDone = 0, shiftUpdate = 0, strobeN = 1;
  logic dataOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [15:0] expWordQ[$];
  string       expTagQ[$];
  logic [15:0] obsQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_status_capture u_dut (
    .clk(clk), .rstN(rstN), .aTrigPulse(aTrigPulse), .bTrigPulse(bTrigPulse),
    .gatePulse(gatePulse), .singleArm(singleArm), .singleDone(singleDone),
    .shiftUpdate(shiftUpdate), .strobeN(strobeN), .dataOut(dataOut)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  task automatic expectWord(input logic [15:0] w, input string tag);
    expWordQ.push_back(w);
    expTagQ.push_back(tag);
  endtask

  task automatic pulse(ref logic sig, input int times);
    for (int i = 0; i < times; i++) begin
      @(negedge clk) sig = 1'b1;
      @(negedge clk) sig = 1'b0;
    end
  endtask

  // read n bits, MSB first; returns the collected bits right-aligned
  task automatic readBits(input int n, output logic [15:0] word);
    word = '0;
    for (int i = 0; i < n; i++) begin
      logic b;
      b = dataOut;
      word = {word[14:0], b};
      @(negedge clk) strobeN = 1'b0;
      @(negedge clk) check("R3 hold while strobe low", {15'd0, dataOut}, {15'd0, b});
      @(negedge clk) strobeN = 1'b1;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic readFrame();
    logic [15:0] w;
    readBits(16, w);
    obsQ.push_back(w);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      wait (obsQ.size() > 0);
      begin
        logic [15:0] o;
        o = obsQ.pop_front();
        if (expWordQ.size() == 0) begin
          check("scoreboard underflow", o, 16'hxxxx);
        end else begin
          string t;
          t = expTagQ.pop_front();
          check(t, o, expWordQ.pop_front());
          check("R11 reserved bits zero", o & 16'h03FE, 16'h0000);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] part;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset output", {15'd0, dataOut}, 16'd0);

    // R1: empty snapshot
    pulse(shiftUpdate, 1);
    expectWord(16'h0000, "R1 empty word");
    readFrame();

    // R4 R6 R7: arm, A trigger, three gates
    pulse(singleArm, 1);
    pulse(aTrigPulse, 1);
    pulse(gatePulse, 3);
    pulse(shiftUpdate, 1);
    expectWord(16'h3801, "R4/R6/R7 A trig, 3 gates, busy");
    readFrame();

    // R8: frame-end snapshot cleared flags; busy persists
    pulse(bTrigPulse, 1);
    pulse(singleDone, 1);
    expectWord(16'h0001, "R8 cleared after readout, R7 busy kept");
    readFrame();
    expectWord(16'h0400, "R5 B trig, R7 single done");
    readFrame();

    // R6 saturation, R2 first bit visible at once
    pulse(gatePulse, 20);
    pulse(shiftUpdate, 1);
    check("R2 MSB shown before strobe", {15'd0, dataOut}, 16'd1);
    expectWord(16'hF000, "R6 saturated count");
    readFrame();

    // R2 partial MSB-first, R9 mid-frame update restart
    pulse(aTrigPulse, 1);
    pulse(shiftUpdate, 1);
    readBits(5, part);
    check("R2 MSB-first order", part, 16'h0001);
    pulse(gatePulse, 2);
    pulse(shiftUpdate, 1);
    expectWord(16'h2000, "R9 restart at MSB");
    readFrame();

    // R10: events in the snapshot cycle
    @(negedge clk);
    shiftUpdate = 1; aTrigPulse = 1; gatePulse = 1;
    @(negedge clk);
    shiftUpdate = 0; aTrigPulse = 0; gatePulse = 0;
    expectWord(16'h0000, "R10 snapshot excludes same-cycle event");
    readFrame();
    expectWord(16'h1800, "R10 same-cycle event kept");
    readFrame();

    repeat (4) @(negedge clk);
    check("scoreboard drained", 16'(expWordQ.size()), 16'd0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule